// File: doc/BRIEF.md
# UART FIFO pair with ready flags

This block sits between an 8-bit host register port and the serial shifters of a UART. Host writes go into a 16-entry transmit queue. The transmit shifter takes them out through a first-word-fall-through handshake. The receive shifter pushes each received byte together with three error bits into a 16-entry receive queue. Host reads pop both the byte and its error bits.

Two active-low pins report buffer state to the host. The receive-ready pin goes low while any received character is waiting. The transmit-ready pin goes low while a transmit slot is free. A receive trigger flag rises once the receive occupancy reaches one of four selectable thresholds.

A synchronous FIFO clear empties both queues without a full reset. A transmit write that finds the queue full is discarded and latches a sticky overflow bit.

Top module: `uart_fifo_pair`

## Requirements
- R1: After `rst`, the outputs are `rxrdy_n`=1, `txrdy_n`=0, `tx_avail`=0, `tx_ovf`=0, `rx_trig`=0 and `host_rd_data`=0.
- R2: Bytes written with `host_wr_en` are presented on `tx_data` in write order. `tx_avail` is 1 while the transmit queue is non-empty. `tx_pop` moves on to the next byte.
- R3: `txrdy_n` is 0 while the transmit queue holds fewer than 16 bytes. It is 1 when the queue holds 16 bytes.
- R4: A write to a full transmit queue is discarded and leaves the stored bytes unchanged. It sets `tx_ovf`, which stays set until `rst` or `fifo_clr`.
- R5: Each receive entry stores `rx_push_data` with `rx_push_err` (bit 2 break, bit 1 framing, bit 0 parity). A `host_rd_en` on a non-empty queue puts the oldest entry on `host_rd_data`/`host_rd_err` one clock later, and the entries come out in push order.
- R6: `rxrdy_n` is 0 whenever at least one received entry is waiting and 1 when the receive queue is empty.
- R7: `rx_trig` is 1 exactly when the receive occupancy is at least the level chosen by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R8: A read of an empty receive queue leaves `host_rd_data`/`host_rd_err` at the last value read and does not move the pointers, so the next pushed entry is read back correctly.
- R9: A push into a full receive queue (16 entries) is discarded.
- R10: `fifo_clr` empties both queues and clears `tx_ovf` and `rx_trig` on the next clock. It keeps the last read value.
- R11: A push and a pop in the same cycle both take effect and leave the occupancy unchanged. On a full transmit queue, the write is discarded (setting `tx_ovf`) while the pop still proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Synchronous clear of both queues |
| host_wr_en | input | 1 | Host write into the transmit queue |
| host_wr_data | input | 8 | Host write byte |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_avail | output | 1 | Transmit queue non-empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_push_data | input | 8 | Received byte |
| rx_push_err | input | 3 | Break, framing, parity error bits |
| host_rd_en | input | 1 | Host read from the receive queue |
| host_rd_data | output | 8 | Last byte read |
| host_rd_err | output | 3 | Error bits of the last byte read |
| trig_sel | input | 2 | Receive trigger level select |
| rx_trig | output | 1 | Receive occupancy at or above trigger |
| rxrdy_n | output | 1 | Active-low receive data waiting |
| txrdy_n | output | 1 | Active-low transmit slot free |

## Verification
The cases where two operations fall in the same cycle are a host write meeting a shifter pop on the transmit side, and a shifter push meeting a host read on the receive side. The bench drives both strobes in the same clock: once with a partly filled queue and once with a full transmit queue. It then judges the result by the ready pins and by draining the queue. The drain must show the exact surviving byte sequence, and in the full case the overflow bit must be set with the dropped byte absent.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int BYTE_W = 8;
    localparam int ERR_W  = 3;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        rx_err_t           err;
    } rx_entry_t;

    localparam int RX_ENTRY_W = $bits(rx_entry_t);

    typedef enum logic [1:0] {
        TRIG_L1  = 2'd0,
        TRIG_L4  = 2'd1,
        TRIG_L8  = 2'd2,
        TRIG_L14 = 2'd3
    } trig_sel_e;

    function automatic int unsigned trig_level(trig_sel_e sel);
        case (sel)
            TRIG_L1:  return 1;
            TRIG_L4:  return 4;
            TRIG_L8:  return 8;
            default:  return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= nxt(wptr);
            end
            if (do_pop) begin
                rptr <= nxt(rptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_trig_detect.sv
module uart_rx_trig_detect
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic      [CW-1:0] count,
    input  trig_sel_e          sel,
    output logic               trig
);

    logic [CW-1:0] level;

    always_comb begin
        level = CW'(trig_level(sel));
        trig  = (count >= level);
    end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_clr,
    input  logic              host_wr_en,
    input  logic [BYTE_W-1:0] host_wr_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_avail,
    output logic              tx_ovf,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_push_data,
    input  logic [ERR_W-1:0]  rx_push_err,
    input  logic              host_rd_en,
    output logic [BYTE_W-1:0] host_rd_data,
    output logic [ERR_W-1:0]  host_rd_err,
    input  logic [1:0]        trig_sel,
    output logic              rx_trig,
    output logic              rxrdy_n,
    output logic              txrdy_n
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] tx_count;
    logic [CW-1:0] rx_count;
    logic          tx_full;
    logic          tx_empty;
    logic          rx_full;
    logic          rx_empty;
    rx_entry_t     rx_in;
    rx_entry_t     rx_head;
    rx_entry_t     rd_q;
    logic [RX_ENTRY_W-1:0] rx_head_raw;

    uart_sync_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (DEPTH)
    ) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (fifo_clr),
        .push      (host_wr_en),
        .push_data (host_wr_data),
        .pop       (tx_pop),
        .head      (tx_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    assign rx_in = '{data: rx_push_data, err: rx_err_t'(rx_push_err)};

    uart_sync_fifo #(
        .WIDTH (RX_ENTRY_W),
        .DEPTH (DEPTH)
    ) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (fifo_clr),
        .push      (rx_push),
        .push_data (rx_in),
        .pop       (host_rd_en),
        .head      (rx_head_raw),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign rx_head = rx_entry_t'(rx_head_raw);

    uart_rx_trig_detect #(
        .CW (CW)
    ) u_trig (
        .count (rx_count),
        .sel   (trig_sel_e'(trig_sel)),
        .trig  (rx_trig)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (host_rd_en && !rx_empty && !fifo_clr) begin
            rd_q <= rx_head;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || fifo_clr) begin
            tx_ovf <= 1'b0;
        end else if (host_wr_en && tx_full) begin
            tx_ovf <= 1'b1;
        end
    end

    assign host_rd_data = rd_q.data;
    assign host_rd_err  = rd_q.err;
    assign tx_avail     = !tx_empty;
    assign txrdy_n      = tx_full;
    assign rxrdy_n      = rx_empty;

    logic unused_rx_full;
    assign unused_rx_full = rx_full;

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_clr,
    input logic          host_wr_en,
    input logic          tx_pop,
    input logic          tx_ovf,
    input logic          tx_avail,
    input logic          rx_push,
    input logic          host_rd_en,
    input logic [7:0]    host_rd_data,
    input logic [2:0]    host_rd_err,
    input logic          rx_trig,
    input logic          rxrdy_n,
    input logic          txrdy_n,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(DEPTH)); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tx_ovf && !fifo_clr) |=> tx_ovf); // R4

    AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && txrdy_n && !fifo_clr) |=> tx_ovf); // R4

    AST_RX_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CW'(DEPTH)); // R9

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && rxrdy_n) |=> ($stable(host_rd_data) && $stable(host_rd_err))); // R8

    AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_trig |-> !rxrdy_n); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (rxrdy_n && !txrdy_n && !tx_avail && !tx_ovf && !rx_trig)); // R10

    AST_TX_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && tx_pop && tx_avail && !txrdy_n && !fifo_clr) |=> $stable(tx_count)); // R11

    AST_RX_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
        (rx_push && host_rd_en && !rxrdy_n && rx_count != CW'(DEPTH) && !fifo_clr)
        |=> $stable(rx_count)); // R11

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fifo_clr     (fifo_clr),
    .host_wr_en   (host_wr_en),
    .tx_pop       (tx_pop),
    .tx_ovf       (tx_ovf),
    .tx_avail     (tx_avail),
    .rx_push      (rx_push),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .host_rd_err  (host_rd_err),
    .rx_trig      (rx_trig),
    .rxrdy_n      (rxrdy_n),
    .txrdy_n      (txrdy_n),
    .tx_count     (tx_count),
    .rx_count     (rx_count)
);

// File: tb/uart_fifo_pair_tb.sv
module uart_fifo_pair_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_clr = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_data;
    logic       tx_avail;
    logic       tx_ovf;
    logic       rx_push = 1'b0;
    logic [7:0] rx_push_data = '0;
    logic [2:0] rx_push_err = '0;
    logic       host_rd_en = 1'b0;
    logic [7:0] host_rd_data;
    logic [2:0] host_rd_err;
    logic [1:0] trig_sel = 2'd0;
    logic       rx_trig;
    logic       rxrdy_n;
    logic       txrdy_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    uart_fifo_pair u_dut (
        .clk          (clk),
        .rst          (rst),
        .fifo_clr     (fifo_clr),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .tx_pop       (tx_pop),
        .tx_data      (tx_data),
        .tx_avail     (tx_avail),
        .tx_ovf       (tx_ovf),
        .rx_push      (rx_push),
        .rx_push_data (rx_push_data),
        .rx_push_err  (rx_push_err),
        .host_rd_en   (host_rd_en),
        .host_rd_data (host_rd_data),
        .host_rd_err  (host_rd_err),
        .trig_sel     (trig_sel),
        .rx_trig      (rx_trig),
        .rxrdy_n      (rxrdy_n),
        .txrdy_n      (txrdy_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        host_wr_en = 1'b1; host_wr_data = b;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic txpop();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic rxpush(input logic [7:0] d, input logic [2:0] e);
        rx_push = 1'b1; rx_push_data = d; rx_push_err = e;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic rd();
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic clear();
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 txrdy_n", txrdy_n, 0);
        chk("R1 tx_avail", tx_avail, 0);
        chk("R1 tx_ovf", tx_ovf, 0);
        chk("R1 rx_trig", rx_trig, 0);
        chk("R1 host_rd_data", host_rd_data, 0);
    endtask

    task automatic t_tx_fill();
        clear();
        for (int i = 0; i < 16; i++) begin
            wr(8'hA0 + 8'(i));
            if (i == 0) chk("R2 tx_avail after write", tx_avail, 1);
            if (i == 14) chk("R3 txrdy_n at 15", txrdy_n, 0);
        end
        chk("R3 txrdy_n at 16", txrdy_n, 1);
        chk("R4 ovf before overflow", tx_ovf, 0);
        wr(8'h55);
        chk("R4 ovf after full write", tx_ovf, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R2 R4 tx order", tx_data, 8'hA0 + 8'(i));
            txpop();
        end
        chk("R2 tx empty", tx_avail, 0);
        chk("R3 txrdy_n empty", txrdy_n, 0);
        chk("R4 ovf sticky", tx_ovf, 1);
        clear();
        chk("R10 ovf cleared", tx_ovf, 0);
    endtask

    task automatic t_rx_basic();
        clear();
        chk("R6 rxrdy_n empty", rxrdy_n, 1);
        rxpush(8'h11, 3'b001);
        chk("R6 rxrdy_n one", rxrdy_n, 0);
        rxpush(8'h22, 3'b010);
        rxpush(8'h33, 3'b100);
        rd();
        chk("R5 data 1", host_rd_data, 8'h11);
        chk("R5 err 1", host_rd_err, 3'b001);
        rd();
        chk("R5 data 2", host_rd_data, 8'h22);
        chk("R5 err 2", host_rd_err, 3'b010);
        rd();
        chk("R5 data 3", host_rd_data, 8'h33);
        chk("R5 err 3", host_rd_err, 3'b100);
        chk("R6 rxrdy_n drained", rxrdy_n, 1);
        rd();
        chk("R8 empty read data", host_rd_data, 8'h33);
        chk("R8 empty read err", host_rd_err, 3'b100);
        rxpush(8'h44, 3'b011);
        rd();
        chk("R8 pointers intact", host_rd_data, 8'h44);
        chk("R8 pointers intact err", host_rd_err, 3'b011);
    endtask

    task automatic t_trig();
        int lv [4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            clear();
            trig_sel = 2'(s);
            @(negedge clk);
            chk("R7 trig empty", rx_trig, 0);
            for (int n = 1; n <= 16; n++) begin
                rxpush(8'(n), 3'b000);
                chk($sformatf("R7 sel%0d n%0d", s, n), rx_trig, (n >= lv[s]) ? 1 : 0);
            end
        end
        rxpush(8'hEE, 3'b111);
        for (int n = 1; n <= 16; n++) rd();
        chk("R9 last stored", host_rd_data, 8'd16);
        chk("R9 drained", rxrdy_n, 1);
        rd();
        chk("R9 dropped entry absent", host_rd_data, 8'd16);
        trig_sel = 2'd0;
    endtask

    task automatic t_clr();
        clear();
        rxpush(8'h5A, 3'b000);
        rxpush(8'h5B, 3'b000);
        wr(8'h01);
        rd();
        chk("R10 setup read", host_rd_data, 8'h5A);
        clear();
        chk("R10 rxrdy_n", rxrdy_n, 1);
        chk("R10 txrdy_n", txrdy_n, 0);
        chk("R10 tx_avail", tx_avail, 0);
        chk("R10 rx_trig", rx_trig, 0);
        chk("R10 read value kept", host_rd_data, 8'h5A);
    endtask

    task automatic t_simul();
        clear();
        wr(8'h10);
        wr(8'h20);
        host_wr_en = 1'b1; host_wr_data = 8'h30; tx_pop = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; tx_pop = 1'b0;
        chk("R11 tx head after both", tx_data, 8'h20);
        txpop();
        chk("R11 tx next", tx_data, 8'h30);
        txpop();
        chk("R11 tx empty after two", tx_avail, 0);
        for (int i = 0; i < 16; i++) wr(8'(i));
        host_wr_en = 1'b1; host_wr_data = 8'h77; tx_pop = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; tx_pop = 1'b0;
        chk("R11 full both ovf", tx_ovf, 1);
        chk("R11 full both txrdy_n", txrdy_n, 0);
        for (int i = 1; i < 16; i++) begin
            chk("R11 full both order", tx_data, 8'(i));
            txpop();
        end
        chk("R11 dropped byte absent", tx_avail, 0);
        clear();
        rxpush(8'hC1, 3'b000);
        rx_push = 1'b1; rx_push_data = 8'hC2; rx_push_err = 3'b010; host_rd_en = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; host_rd_en = 1'b0;
        chk("R11 rx read during push", host_rd_data, 8'hC1);
        chk("R11 rx still ready", rxrdy_n, 0);
        rd();
        chk("R11 rx pushed entry", host_rd_data, 8'hC2);
        chk("R11 rx drained", rxrdy_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_fill();
        t_rx_basic();
        t_trig();
        t_clr();
        t_simul();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=1 exp=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule